// File: doc/BRIEF.md
# Remote management command decoder

This block sits behind a system-management bus slave port. An external controller writes a single command-type byte. The block turns that byte into system-control actions. Some actions are one-clock pulses to neighbouring logic: a wake request, an SMI request, a power-button override, a reset-control write and a watchdog reload. Other actions set status bits that software reads and clears by writing ones.

A disable-messages command drops the heartbeat/event message enable for good. Software has no way to restore it. Only the resume-well reset, asserted and then released, brings it back. The same reset is the only one that clears the two status bits. The power sequencer, the watchdog counter and the message generator are outside this block.

Each action leaves the block from a register. Its pulse appears in the clock cycle that follows the clock edge at which the write strobe was sampled.

Top module: `mgmt_cmd_decoder`

## Requirements
- R1: While `rsmRstN` is low, every pulse output is 0, `rstCtrlValue` is 0, both status bits are 0 and `msgEnable` is 1.
- R2: Command byte 0x01, strobed while `sysAwake` is 0, gives a one-cycle `wakePulse` and no `smiPulse`.
- R3: Command byte 0x01, strobed while `sysAwake` is 1, gives a one-cycle `smiPulse` and no `wakePulse`.
- R4: Command byte 0x01 sets `wakeSts` whether or not the system is awake.
- R5: Command byte 0x02 gives a one-cycle `pwrOverridePulse` and sets `pwrOvrSts`.
- R6: Command byte 0x03 gives `rstCtrlWrite` with `rstCtrlValue` = 4'b0110 (bits 2 and 1 set, bit 3 clear). Command byte 0x04 gives `rstCtrlWrite` with `rstCtrlValue` = 4'b1110 (bits 3 to 1 set). Outside such a pulse, `rstCtrlValue` is 0.
- R7: Command byte 0x05 clears `msgEnable`. It stays 0 through any later command or software clear, and returns to 1 only through `rsmRstN`.
- R8: Command byte 0x06 gives a one-cycle `wdReloadPulse`.
- R9: Command bytes 0x00 and 0x07 to 0xFF change no output.
- R10: A pulse appears only in the cycle after a strobed command. With `cmdValid` low, no pulse output rises.
- R11: `swClrValid` with a mask bit of 1 clears the matching status bit. Mask bit 0 clears `wakeSts` and mask bit 1 clears `pwrOvrSts`. Other status bits keep their value.
- R12: When a status bit's set and clear fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rsmRstN | input | 1 | Resume-well reset, asynchronous, active low |
| cmdValid | input | 1 | Write strobe for the command byte |
| cmdByte | input | 8 | Command-type byte |
| sysAwake | input | 1 | High when the system is running |
| swClrValid | input | 1 | Software write-one-to-clear strobe |
| swClrMask | input | 2 | Bit 0 clears wakeSts, bit 1 clears pwrOvrSts |
| wakePulse | output | 1 | Wake request pulse |
| smiPulse | output | 1 | SMI request pulse |
| pwrOverridePulse | output | 1 | Power-button override pulse |
| rstCtrlWrite | output | 1 | Emulated reset-control write pulse |
| rstCtrlValue | output | 4 | Value of the emulated reset-control write |
| wdReloadPulse | output | 1 | Watchdog reload pulse |
| wakeSts | output | 1 | Wake status bit |
| pwrOvrSts | output | 1 | Power-override status bit |
| msgEnable | output | 1 | Heartbeat/event message enable |

## Verification
The wake command is sent once with the system asleep and once with it awake. This separates the wake path from the SMI path and shows that the status bit is set in both cases. Both reset commands are sent one after the other, so a swap of their reset-control values shows up. Reserved bytes at both ends of the range and in its middle are checked against an unchanged output set. A status clear is sent in the same cycle as a setting command, which exposes a wrong priority. After disable-messages, further commands, clears and finally a resume-well reset tell apart a true one-way latch, one that software can clear, and one that never recovers.

// File: rtl/mgmt_cmd_pkg.sv
package mgmt_cmd_pkg;

  localparam int CMD_W      = 8;
  localparam int STS_W      = 2;
  localparam int RST_CTRL_W = 4;

  // status bit positions in the software clear mask
  localparam int STS_WAKE = 0;
  localparam int STS_PWR  = 1;

  // reset-control bit positions
  localparam int RC_SYS  = 1;
  localparam int RC_CPU  = 2;
  localparam int RC_FULL = 3;

  localparam logic [RST_CTRL_W-1:0] RC_WARM_VAL =
    RST_CTRL_W'((1 << RC_SYS) | (1 << RC_CPU));
  localparam logic [RST_CTRL_W-1:0] RC_COLD_VAL =
    RST_CTRL_W'((1 << RC_SYS) | (1 << RC_CPU) | (1 << RC_FULL));

  typedef enum logic [CMD_W-1:0] {
    CMD_RSVD_LOW  = 8'h00,
    CMD_WAKE      = 8'h01,
    CMD_PWR_DOWN  = 8'h02,
    CMD_RST_WARM  = 8'h03,
    CMD_RST_COLD  = 8'h04,
    CMD_MSG_OFF   = 8'h05,
    CMD_WD_RELOAD = 8'h06
  } cmd_e;

  typedef struct packed {
    logic doWake;
    logic doSmi;
    logic doPwrDown;
    logic doRstWarm;
    logic doRstCold;
    logic doMsgOff;
    logic doWdReload;
  } act_strobe_t;

endpackage

// File: rtl/mgmt_cmd_ctrl.sv
module mgmt_cmd_ctrl
  import mgmt_cmd_pkg::*;
(
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdByte,
  input  logic             sysAwake,
  output act_strobe_t      act
);

  logic hitWake, hitPwr, hitWarm, hitCold, hitMsg, hitWd;

  always_comb begin
    hitWake = 1'b0;
    hitPwr  = 1'b0;
    hitWarm = 1'b0;
    hitCold = 1'b0;
    hitMsg  = 1'b0;
    hitWd   = 1'b0;
    if (cmdValid) begin
      case (cmdByte)
        CMD_WAKE:      hitWake = 1'b1;
        CMD_PWR_DOWN:  hitPwr  = 1'b1;
        CMD_RST_WARM:  hitWarm = 1'b1;
        CMD_RST_COLD:  hitCold = 1'b1;
        CMD_MSG_OFF:   hitMsg  = 1'b1;
        CMD_WD_RELOAD: hitWd   = 1'b1;
        default:       ; // reserved codes: no action
      endcase
    end
  end

  always_comb begin
    act            = '0;
    act.doWake     = hitWake & ~sysAwake;
    act.doSmi      = hitWake &  sysAwake;
    act.doPwrDown  = hitPwr;
    act.doRstWarm  = hitWarm;
    act.doRstCold  = hitCold;
    act.doMsgOff   = hitMsg;
    act.doWdReload = hitWd;
  end

endmodule

// File: rtl/mgmt_cmd_datapath.sv
module mgmt_cmd_datapath
  import mgmt_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rsmRstN,
  input  act_strobe_t           act,
  input  logic                  swClrValid,
  input  logic [STS_W-1:0]      swClrMask,
  output logic                  wakePulse,
  output logic                  smiPulse,
  output logic                  pwrOverridePulse,
  output logic                  rstCtrlWrite,
  output logic [RST_CTRL_W-1:0] rstCtrlValue,
  output logic                  wdReloadPulse,
  output logic [STS_W-1:0]      stsBits,
  output logic                  msgEnable
);

  logic [STS_W-1:0]      stsSet;
  logic [RST_CTRL_W-1:0] rcNext;

  always_comb begin
    stsSet           = '0;
    stsSet[STS_WAKE] = act.doWake | act.doSmi;
    stsSet[STS_PWR]  = act.doPwrDown;
  end

  always_comb begin
    if (act.doRstCold)      rcNext = RC_COLD_VAL;
    else if (act.doRstWarm) rcNext = RC_WARM_VAL;
    else                    rcNext = '0;
  end

  // action pulses
  always_ff @(posedge clk or negedge rsmRstN) begin
    if (!rsmRstN) begin
      wakePulse        <= 1'b0;
      smiPulse         <= 1'b0;
      pwrOverridePulse <= 1'b0;
      rstCtrlWrite     <= 1'b0;
      rstCtrlValue     <= '0;
      wdReloadPulse    <= 1'b0;
    end else begin
      wakePulse        <= act.doWake;
      smiPulse         <= act.doSmi;
      pwrOverridePulse <= act.doPwrDown;
      rstCtrlWrite     <= act.doRstWarm | act.doRstCold;
      rstCtrlValue     <= rcNext;
      wdReloadPulse    <= act.doWdReload;
    end
  end

  // sticky status bits, set wins over a software clear
  for (genvar i = 0; i < STS_W; i++) begin : g_sts
    always_ff @(posedge clk or negedge rsmRstN) begin
      if (!rsmRstN)                        stsBits[i] <= 1'b0;
      else if (stsSet[i])                  stsBits[i] <= 1'b1;
      else if (swClrValid && swClrMask[i]) stsBits[i] <= 1'b0;
    end
  end

  // one-way message enable latch
  always_ff @(posedge clk or negedge rsmRstN) begin
    if (!rsmRstN)         msgEnable <= 1'b1;
    else if (act.doMsgOff) msgEnable <= 1'b0;
  end

endmodule

// File: rtl/mgmt_cmd_decoder.sv
module mgmt_cmd_decoder
  import mgmt_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rsmRstN,
  input  logic                  cmdValid,
  input  logic [CMD_W-1:0]      cmdByte,
  input  logic                  sysAwake,
  input  logic                  swClrValid,
  input  logic [STS_W-1:0]      swClrMask,
  output logic                  wakePulse,
  output logic                  smiPulse,
  output logic                  pwrOverridePulse,
  output logic                  rstCtrlWrite,
  output logic [RST_CTRL_W-1:0] rstCtrlValue,
  output logic                  wdReloadPulse,
  output logic                  wakeSts,
  output logic                  pwrOvrSts,
  output logic                  msgEnable
);

  act_strobe_t      act;
  logic [STS_W-1:0] stsBits;

  mgmt_cmd_ctrl u_ctrl (
    .cmdValid (cmdValid),
    .cmdByte  (cmdByte),
    .sysAwake (sysAwake),
    .act      (act)
  );

  mgmt_cmd_datapath u_dp (
    .clk              (clk),
    .rsmRstN          (rsmRstN),
    .act              (act),
    .swClrValid       (swClrValid),
    .swClrMask        (swClrMask),
    .wakePulse        (wakePulse),
    .smiPulse         (smiPulse),
    .pwrOverridePulse (pwrOverridePulse),
    .rstCtrlWrite     (rstCtrlWrite),
    .rstCtrlValue     (rstCtrlValue),
    .wdReloadPulse    (wdReloadPulse),
    .stsBits          (stsBits),
    .msgEnable        (msgEnable)
  );

  assign wakeSts   = stsBits[STS_WAKE];
  assign pwrOvrSts = stsBits[STS_PWR];

endmodule

// File: rtl/mgmt_cmd_checker.sv
module mgmt_cmd_checker
  import mgmt_cmd_pkg::*;
(
  input logic                  clk,
  input logic                  rsmRstN,
  input logic                  cmdValid,
  input logic                  swClrValid,
  input logic [STS_W-1:0]      swClrMask,
  input logic                  wakePulse,
  input logic                  smiPulse,
  input logic                  pwrOverridePulse,
  input logic                  rstCtrlWrite,
  input logic [RST_CTRL_W-1:0] rstCtrlValue,
  input logic                  wdReloadPulse,
  input logic                  wakeSts,
  input logic                  pwrOvrSts,
  input logic                  msgEnable
);

  logic anyPulse;
  assign anyPulse = wakePulse | smiPulse | pwrOverridePulse | rstCtrlWrite | wdReloadPulse;

  AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rsmRstN)
    cmdValid == 1'b0 |=> !anyPulse); // R10

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rsmRstN)
    $onehot0({wakePulse, smiPulse, pwrOverridePulse, rstCtrlWrite, wdReloadPulse})); // R10

  AST_WAKE_SETS_STS: assert property (@(posedge clk) disable iff (!rsmRstN)
    (wakePulse || smiPulse) |-> wakeSts); // R4

  AST_PWR_SETS_STS: assert property (@(posedge clk) disable iff (!rsmRstN)
    pwrOverridePulse |-> pwrOvrSts); // R5

  AST_RST_VALUE_SHAPE: assert property (@(posedge clk) disable iff (!rsmRstN)
    rstCtrlWrite |-> (rstCtrlValue[2:0] == 3'b110)); // R6

  AST_RST_VALUE_IDLE: assert property (@(posedge clk) disable iff (!rsmRstN)
    !rstCtrlWrite |-> (rstCtrlValue == '0)); // R6

  AST_MSG_ONE_WAY: assert property (@(posedge clk) disable iff (!rsmRstN)
    !msgEnable |=> !msgEnable); // R7

  AST_WAKE_STS_HOLD: assert property (@(posedge clk) disable iff (!rsmRstN)
    (wakeSts && !(swClrValid && swClrMask[STS_WAKE])) |=> wakeSts); // R11

  AST_PWR_STS_HOLD: assert property (@(posedge clk) disable iff (!rsmRstN)
    (pwrOvrSts && !(swClrValid && swClrMask[STS_PWR])) |=> pwrOvrSts); // R11

endmodule

bind mgmt_cmd_decoder mgmt_cmd_checker u_chk (
  .clk              (clk),
  .rsmRstN          (rsmRstN),
  .cmdValid         (cmdValid),
  .swClrValid       (swClrValid),
  .swClrMask        (swClrMask),
  .wakePulse        (wakePulse),
  .smiPulse         (smiPulse),
  .pwrOverridePulse (pwrOverridePulse),
  .rstCtrlWrite     (rstCtrlWrite),
  .rstCtrlValue     (rstCtrlValue),
  .wdReloadPulse    (wdReloadPulse),
  .wakeSts          (wakeSts),
  .pwrOvrSts        (pwrOvrSts),
  .msgEnable        (msgEnable)
);

// File: tb/mgmt_cmd_decoder_bench.sv
module mgmt_cmd_decoder_bench;

  typedef struct packed {
    logic       wake;
    logic       smi;
    logic       pwr;
    logic       rstWr;
    logic [3:0] rstVal;
    logic       wd;
    logic       wakeS;
    logic       pwrS;
    logic       msgEn;
  } obs_t;

  logic       clk = 1'b0;
  logic       rsmRstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdByte = 8'h00;
  logic       sysAwake = 1'b0;
  logic       swClrValid = 1'b0;
  logic [1:0] swClrMask = 2'b00;
  logic       wakePulse, smiPulse, pwrOverridePulse, rstCtrlWrite, wdReloadPulse;
  logic [3:0] rstCtrlValue;
  logic       wakeSts, pwrOvrSts, msgEnable;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  obs_t  expQ[$];
  string tagQ[$];

  // bench model state
  logic mWake = 1'b0, mPwr = 1'b0, mMsg = 1'b1;

  always #10 clk = ~clk; // 50 MHz

  mgmt_cmd_decoder u_mgmt_cmd_decoder (
    .clk(clk), .rsmRstN(rsmRstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .sysAwake(sysAwake), .swClrValid(swClrValid), .swClrMask(swClrMask),
    .wakePulse(wakePulse), .smiPulse(smiPulse), .pwrOverridePulse(pwrOverridePulse),
    .rstCtrlWrite(rstCtrlWrite), .rstCtrlValue(rstCtrlValue), .wdReloadPulse(wdReloadPulse),
    .wakeSts(wakeSts), .pwrOvrSts(pwrOvrSts), .msgEnable(msgEnable)
  );

  function automatic obs_t sample();
    obs_t o;
    o.wake = wakePulse; o.smi = smiPulse; o.pwr = pwrOverridePulse;
    o.rstWr = rstCtrlWrite; o.rstVal = rstCtrlValue; o.wd = wdReloadPulse;
    o.wakeS = wakeSts; o.pwrS = pwrOvrSts; o.msgEn = msgEnable;
    return o;
  endfunction

  // driver: one cycle of stimulus plus its expected result
  task automatic step(input logic rst, input logic v, input logic [7:0] b,
                      input logic awake, input logic cv, input logic [1:0] cm,
                      input string tag);
    obs_t e;
    logic setW, setP;
    @(negedge clk);
    rsmRstN = rst; cmdValid = v; cmdByte = b; sysAwake = awake;
    swClrValid = cv; swClrMask = cm;
    e = '0;
    if (!rst) begin
      mWake = 1'b0; mPwr = 1'b0; mMsg = 1'b1;
    end else begin
      setW = v && b == 8'h01;
      setP = v && b == 8'h02;
      e.wake = setW && !awake;
      e.smi  = setW && awake;
      e.pwr  = setP;
      e.rstWr = v && (b == 8'h03 || b == 8'h04);
      e.rstVal = (v && b == 8'h03) ? 4'b0110 : (v && b == 8'h04) ? 4'b1110 : 4'b0000;
      e.wd = v && b == 8'h06;
      if (setW) mWake = 1'b1; else if (cv && cm[0]) mWake = 1'b0;
      if (setP) mPwr = 1'b1;  else if (cv && cm[1]) mPwr = 1'b0;
      if (v && b == 8'h05) mMsg = 1'b0;
    end
    e.wakeS = mWake; e.pwrS = mPwr; e.msgEn = mMsg;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // monitor: compares after each rising edge
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) begin
      obs_t e, a;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a = sample();
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s actual=%b expected=%b", t, a, e);
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(0, 0, 8'h00, 0, 0, 2'b00, "R1 reset");
    step(0, 1, 8'h01, 0, 0, 2'b00, "R1 strobe during reset");
    step(1, 0, 8'h00, 0, 0, 2'b00, "R10 idle");
    step(1, 0, 8'h01, 0, 0, 2'b00, "R10 byte without strobe");
    step(1, 1, 8'h01, 0, 0, 2'b00, "R2 R4 wake asleep");
    step(1, 0, 8'h00, 0, 0, 2'b00, "R2 pulse one cycle");
    step(1, 0, 8'h00, 0, 1, 2'b01, "R11 clear wake");
    step(1, 1, 8'h01, 1, 0, 2'b00, "R3 R4 wake awake smi");
    step(1, 1, 8'h01, 1, 1, 2'b01, "R12 set beats clear");
    step(1, 1, 8'h02, 0, 0, 2'b00, "R5 power override");
    step(1, 0, 8'h00, 0, 1, 2'b10, "R11 clear pwr only");
    step(1, 1, 8'h03, 0, 0, 2'b00, "R6 warm reset");
    step(1, 1, 8'h04, 0, 0, 2'b00, "R6 cold reset");
    step(1, 1, 8'h06, 0, 0, 2'b00, "R8 wd reload");
    step(1, 1, 8'h06, 0, 0, 2'b00, "R8 wd reload again");
    step(1, 0, 8'h00, 0, 1, 2'b11, "R11 clear both");
    step(1, 1, 8'h02, 0, 1, 2'b10, "R12 pwr set beats clear");
    step(1, 1, 8'h00, 0, 0, 2'b00, "R9 reserved 00");
    step(1, 1, 8'h07, 1, 0, 2'b00, "R9 reserved 07");
    step(1, 1, 8'h80, 0, 0, 2'b00, "R9 reserved 80");
    step(1, 1, 8'hFF, 1, 0, 2'b00, "R9 reserved FF");
    step(1, 1, 8'h05, 0, 0, 2'b00, "R7 message disable");
    step(1, 1, 8'h01, 0, 0, 2'b00, "R7 stays off after command");
    step(1, 0, 8'h00, 0, 1, 2'b11, "R7 stays off after clear");
    step(1, 1, 8'h05, 0, 0, 2'b00, "R7 repeated disable");
    step(0, 0, 8'h00, 0, 0, 2'b00, "R7 R1 resume reset");
    step(1, 0, 8'h00, 0, 0, 2'b00, "R7 enabled after release");
    step(1, 0, 8'h00, 0, 0, 2'b00, "R10 final idle");
    @(posedge clk); #7;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule